// File: doc/BRIEF.md
# Target initial latency controller

This block sets how long a bus target waits before it presents its first data phase. When a transaction begins it works out an effective latency from four things: the programmed initial latency, the address decode speed (A, B or C), the number of address phases, and the kind of bus event that came just before. It then counts clocks and raises a one-cycle ready strobe when that latency has elapsed. The effective latency is the largest of three values:

- the programmed value;
- a floor set by the decode speed plus the number of address phases;
- a floor of 15 clocks that applies to a read from this target when the previous bus event makes a turnaround necessary.

A small history register holds the kind of the last completed bus event. The surrounding logic reports each event through `evt_done` and `evt_kind`.

The sequencing is a three-state machine:

- **IDLE** waits for a start.
- **COUNT** runs a down-counter.
- **FIRE** is the single cycle in which `first_ready` is high.

The transitions are:

- *IDLE→FIRE*: a start whose effective latency is 1.
- *IDLE→COUNT*: a start whose effective latency is larger than 1.
- *COUNT→COUNT*: counting down.
- *COUNT→FIRE*: the count is exhausted.
- *COUNT→IDLE*: abort.
- *FIRE→IDLE*: no new start.
- *FIRE→COUNT* or *FIRE→FIRE*: a new start in the ready cycle.

Top module: `tgt_latency_ctrl`

## Requirements
- R1: Reset is active low. After reset `first_ready` is low, and the event history holds "no event" (code 0), so the first read carries no 15-clock floor.
- R2: The speed floor is the decode-speed minimum plus `addr_phases`. For `dec_speed` code 0 (speed A) the minimum is 2. For codes 1 (B), 2 (C) and 3 (treated as C) the minimum is 1. The effective latency is never below this floor.
- R3: When `prog_lat` exceeds every floor, the effective latency equals `prog_lat`.
- R4: A read start (`txn_is_read`=1) whose recorded previous event is one of the following gets an effective latency of at least 15:
  - code 1, write to this target;
  - code 3, read from another target address;
  - code 4, master write;
  - code 5, master read.
- R5: The 15-clock floor does not apply to a write start, or to a read whose previous event is code 0 (none), code 2 (read from this target), or code 6 or 7.
- R6: With `txn_start` high in clock cycle 0 and effective latency L, `first_ready` is high in cycle L only, for exactly one cycle.
- R7: Abort while counting returns the block to IDLE with no ready strobe. Abort in the same cycle as a start cancels that start.
- R8: A `txn_start` that arrives while the block is in COUNT is ignored. The running count and its ready cycle are unchanged.
- R9: An `evt_done` pulse records `evt_kind` as the latest event. A start in the same cycle as `evt_done` is judged on the event recorded before that pulse.
- R10: A start in the ready cycle (FIRE) is accepted. Its ready strobe follows L cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | One-cycle pulse that begins a target transaction |
| txn_is_read | input | 1 | The transaction being started is a read from this target |
| abort | input | 1 | Cancels a running count, or a start in the same cycle |
| dec_speed | input | 2 | Decode speed: 0 = A, 1 = B, 2 = C, 3 = treated as C |
| addr_phases | input | APH_W (2) | Number of address phases of the transaction |
| prog_lat | input | LAT_W (8) | Programmed initial latency in clocks |
| evt_done | input | 1 | Pulse: a bus event has completed |
| evt_kind | input | 3 | Kind of the completed event (codes listed in R4 and R5) |
| first_ready | output | 1 | One-cycle strobe: the first data phase may proceed |

## Verification
The assertions assume the following about the inputs:
- `txn_start`, `abort` and `evt_done` are qualified by a synchronous, active-low reset.
- `prog_lat` and `addr_phases` are held stable during the start cycle, when they are sampled.
- Every floor fits in the latency field.

The stimulus keeps within these assumptions:
- Fields are driven only on the falling edge.
- Every pulse lasts one clock.
- `prog_lat` is drawn below 48 in the random part.
- `evt_kind` covers all eight codes, including the reserved ones.

Directed cases place abort, a second start, and an event report at the cycles where the state machine is most sensitive to them.

// File: rtl/tlat_pkg.sv
package tlat_pkg;

    typedef enum logic [1:0] {
        SPD_A   = 2'd0,
        SPD_B   = 2'd1,
        SPD_C   = 2'd2,
        SPD_RSV = 2'd3
    } dec_speed_e;

    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_TGT_WR = 3'd1,
        EV_TGT_RD = 3'd2,
        EV_OTH_RD = 3'd3,
        EV_MST_WR = 3'd4,
        EV_MST_RD = 3'd5,
        EV_RSV6   = 3'd6,
        EV_RSV7   = 3'd7
    } bus_event_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } lat_state_e;

    // Events after which a read from this target needs a long turnaround.
    function automatic logic needs_turnaround(input bus_event_e kind);
        logic hit;
        unique case (kind)
            EV_TGT_WR, EV_OTH_RD, EV_MST_WR, EV_MST_RD: hit = 1'b1;
            default:                                    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/tlat_hist.sv
module tlat_hist
    import tlat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_done,
    input  logic [2:0] evt_kind,
    output bus_event_e last_evt
);

    bus_event_e hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= EV_NONE;
        end else if (evt_done) begin
            hist_q <= bus_event_e'(evt_kind);
        end
    end

    assign last_evt = hist_q;

    AST_HIST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> (hist_q == bus_event_e'($past(evt_kind))));  // R9

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_done && $past(rst_n)) |=> $stable(hist_q));  // R9

endmodule

// File: rtl/tlat_calc.sv
module tlat_calc
    import tlat_pkg::*;
#(
    parameter int LAT_W       = 8,
    parameter int APH_W       = 2,
    parameter int MIN_WAIT_A  = 2,
    parameter int MIN_WAIT_BC = 1,
    parameter int TURN_FLOOR  = 15,
    localparam int EFF_W      = LAT_W + 1
) (
    input  logic [LAT_W-1:0] prog_lat,
    input  logic [1:0]       dec_speed,
    input  logic [APH_W-1:0] addr_phases,
    input  logic             is_read,
    input  bus_event_e       last_evt,
    output logic [EFF_W-1:0] eff_lat
);

    logic [EFF_W-1:0] spd_min;
    logic [EFF_W-1:0] spd_floor;
    logic [EFF_W-1:0] turn_floor;
    logic [EFF_W-1:0] prog_ext;
    logic [EFF_W-1:0] max_a;

    always_comb begin
        unique case (dec_speed_e'(dec_speed))
            SPD_A:   spd_min = EFF_W'(MIN_WAIT_A);
            default: spd_min = EFF_W'(MIN_WAIT_BC);
        endcase
    end

    assign spd_floor  = spd_min + EFF_W'(addr_phases);
    assign turn_floor = (is_read && needs_turnaround(last_evt)) ? EFF_W'(TURN_FLOOR) : '0;
    assign prog_ext   = EFF_W'(prog_lat);

    assign max_a   = (prog_ext > spd_floor) ? prog_ext : spd_floor;
    assign eff_lat = (max_a > turn_floor) ? max_a : turn_floor;

endmodule

// File: rtl/tlat_fsm.sv
module tlat_fsm
    import tlat_pkg::*;
#(
    parameter int EFF_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [EFF_W-1:0] eff_lat,
    output logic             ready
);

    lat_state_e       state_q, state_d;
    logic [EFF_W-1:0] cnt_q, cnt_d;
    logic             accept;

    assign accept = start && !abort;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_FIRE: begin
                if (accept) begin
                    cnt_d   = eff_lat - EFF_W'(1);
                    state_d = (eff_lat <= EFF_W'(1)) ? ST_FIRE : ST_COUNT;
                end else begin
                    cnt_d   = '0;
                    state_d = ST_IDLE;
                end
            end
            ST_COUNT: begin
                if (abort) begin
                    cnt_d   = '0;
                    state_d = ST_IDLE;
                end else if (cnt_q <= EFF_W'(1)) begin
                    cnt_d   = '0;
                    state_d = ST_FIRE;
                end else begin
                    cnt_d = cnt_q - EFF_W'(1);
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = ST_IDLE;
            end
        endcase
    end

    assign ready = (state_q == ST_FIRE);

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !accept) |=> !ready);  // R6

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && abort) |=> (!ready && state_q == ST_IDLE));  // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !abort && cnt_q > EFF_W'(1))
            |=> (state_q == ST_COUNT && cnt_q == $past(cnt_q) - EFF_W'(1)));  // R8

    AST_CANCELLED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_COUNT && start && abort) |=> (state_q == ST_IDLE));  // R7

endmodule

// File: rtl/tgt_latency_ctrl.sv
module tgt_latency_ctrl
    import tlat_pkg::*;
#(
    parameter int LAT_W       = 8,
    parameter int APH_W       = 2,
    parameter int MIN_WAIT_A  = 2,
    parameter int MIN_WAIT_BC = 1,
    parameter int TURN_FLOOR  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_start,
    input  logic             txn_is_read,
    input  logic             abort,
    input  logic [1:0]       dec_speed,
    input  logic [APH_W-1:0] addr_phases,
    input  logic [LAT_W-1:0] prog_lat,
    input  logic             evt_done,
    input  logic [2:0]       evt_kind,
    output logic             first_ready
);

    localparam int EFF_W = LAT_W + 1;

    bus_event_e       last_evt;
    logic [EFF_W-1:0] eff_lat;

    tlat_hist u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_done (evt_done),
        .evt_kind (evt_kind),
        .last_evt (last_evt)
    );

    tlat_calc #(
        .LAT_W       (LAT_W),
        .APH_W       (APH_W),
        .MIN_WAIT_A  (MIN_WAIT_A),
        .MIN_WAIT_BC (MIN_WAIT_BC),
        .TURN_FLOOR  (TURN_FLOOR)
    ) u_calc (
        .prog_lat    (prog_lat),
        .dec_speed   (dec_speed),
        .addr_phases (addr_phases),
        .is_read     (txn_is_read),
        .last_evt    (last_evt),
        .eff_lat     (eff_lat)
    );

    tlat_fsm #(
        .EFF_W (EFF_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (txn_start),
        .abort   (abort),
        .eff_lat (eff_lat),
        .ready   (first_ready)
    );

    AST_SPEED_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |-> (eff_lat >= EFF_W'(addr_phases) +
                       ((dec_speed == 2'd0) ? EFF_W'(MIN_WAIT_A) : EFF_W'(MIN_WAIT_BC))));  // R2

    AST_PROG_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |-> (eff_lat >= EFF_W'(prog_lat)));  // R3

    AST_TURN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && txn_is_read &&
         (last_evt == EV_TGT_WR || last_evt == EV_OTH_RD ||
          last_evt == EV_MST_WR || last_evt == EV_MST_RD))
            |-> (eff_lat >= EFF_W'(TURN_FLOOR)));  // R4

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !first_ready);  // R1

endmodule

// File: tb/tb_tgt_latency_ctrl.sv
`timescale 1ns/1ps
module tb_tgt_latency_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       txn_start;
    logic       txn_is_read;
    logic       abort;
    logic [1:0] dec_speed;
    logic [1:0] addr_phases;
    logic [7:0] prog_lat;
    logic       evt_done;
    logic [2:0] evt_kind;
    logic       first_ready;

    int checks = 0;
    int errors = 0;
    int hist_m = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tgt_latency_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_start   (txn_start),
        .txn_is_read (txn_is_read),
        .abort       (abort),
        .dec_speed   (dec_speed),
        .addr_phases (addr_phases),
        .prog_lat    (prog_lat),
        .evt_done    (evt_done),
        .evt_kind    (evt_kind),
        .first_ready (first_ready)
    );

    function automatic int exp_lat(int prog, int spd, int aph, bit rd, int hist);
        int l = prog;
        int f = ((spd == 0) ? 2 : 1) + aph;
        if (f > l) l = f;
        if (rd && (hist == 1 || hist == 3 || hist == 4 || hist == 5) && l < 15) l = 15;
        return l;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic send_evt(input int k);
        @(negedge clk);
        evt_done = 1'b1;
        evt_kind = 3'(k);
        @(negedge clk);
        evt_done = 1'b0;
        hist_m = k;
    endtask

    // Starts one transaction and checks the ready position and pulse count.
    task automatic run_txn(input int prog, input int spd, input int aph, input bit rd,
                           input bit with_evt, input int evk, input string req);
        int l = exp_lat(prog, spd, aph, rd, hist_m);
        int first = 0;
        int pulses = 0;
        @(negedge clk);
        txn_start   = 1'b1;
        txn_is_read = rd;
        prog_lat    = 8'(prog);
        dec_speed   = 2'(spd);
        addr_phases = 2'(aph);
        if (with_evt) begin
            evt_done = 1'b1;
            evt_kind = 3'(evk);
        end
        @(negedge clk);
        txn_start = 1'b0;
        evt_done  = 1'b0;
        if (with_evt) hist_m = evk;
        for (int j = 1; j <= l + 3; j++) begin
            if (first_ready) begin
                pulses++;
                if (first == 0) first = j;
            end
            @(negedge clk);
        end
        check(first == l && pulses == 1, req, first * 100 + pulses, l * 100 + 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; txn_start = 1'b0; txn_is_read = 1'b0; abort = 1'b0;
        dec_speed = 2'd0; addr_phases = 2'd0; prog_lat = 8'd0;
        evt_done = 1'b0; evt_kind = 3'd0;
        repeat (4) @(negedge clk);
        check(first_ready == 1'b0, "R1 ready low in reset", first_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(first_ready == 1'b0, "R1 ready low after reset", first_ready, 0);

        // R1: history empty, so a read gets only the speed floor (B, 1 phase -> 2)
        run_txn(0, 1, 1, 1'b1, 1'b0, 0, "R1 empty history read");
        // R2: speed A floor
        run_txn(0, 0, 1, 1'b0, 1'b0, 0, "R2 speed A floor");
        run_txn(0, 0, 3, 1'b0, 1'b0, 0, "R2 speed A three phases");
        run_txn(0, 2, 0, 1'b0, 1'b0, 0, "R2 speed C no phase latency 1");
        run_txn(0, 3, 2, 1'b0, 1'b0, 0, "R2 speed code 3 as C");
        // R3: programmed value dominates
        run_txn(30, 0, 2, 1'b0, 1'b0, 0, "R3 programmed latency");
        // R4: each turnaround kind
        send_evt(1); run_txn(2, 1, 1, 1'b1, 1'b0, 0, "R4 after target write");
        send_evt(3); run_txn(2, 1, 1, 1'b1, 1'b0, 0, "R4 after other-address read");
        send_evt(4); run_txn(2, 0, 2, 1'b1, 1'b0, 0, "R4 after master write");
        send_evt(5); run_txn(2, 1, 1, 1'b1, 1'b0, 0, "R4 after master read");
        send_evt(5); run_txn(20, 1, 1, 1'b1, 1'b0, 0, "R4 programmed above floor");
        // R5: no floor cases
        send_evt(4); run_txn(3, 1, 1, 1'b0, 1'b0, 0, "R5 write after master write");
        send_evt(2); run_txn(3, 1, 1, 1'b1, 1'b0, 0, "R5 read after own read");
        send_evt(6); run_txn(3, 1, 1, 1'b1, 1'b0, 0, "R5 read after reserved kind");
        // R9: a concurrent event does not affect the start that shares its cycle
        send_evt(4);
        run_txn(2, 1, 1, 1'b1, 1'b1, 2, "R9 concurrent event uses prior history");
        run_txn(2, 1, 1, 1'b1, 1'b0, 0, "R9 new history applies next");

        // R7: abort mid-count suppresses ready
        begin
            int pulses = 0;
            @(negedge clk);
            txn_start = 1'b1; txn_is_read = 1'b0; prog_lat = 8'd20; dec_speed = 2'd1; addr_phases = 2'd1;
            @(negedge clk);
            txn_start = 1'b0;
            for (int j = 1; j <= 26; j++) begin
                if (first_ready) pulses++;
                if (j == 5) abort = 1'b1;
                if (j == 6) abort = 1'b0;
                @(negedge clk);
            end
            check(pulses == 0, "R7 abort mid-count", pulses, 0);
        end
        // R7: abort in the start cycle cancels it
        begin
            int pulses = 0;
            @(negedge clk);
            txn_start = 1'b1; abort = 1'b1; prog_lat = 8'd4;
            @(negedge clk);
            txn_start = 1'b0; abort = 1'b0;
            for (int j = 1; j <= 10; j++) begin
                if (first_ready) pulses++;
                @(negedge clk);
            end
            check(pulses == 0, "R7 abort with start", pulses, 0);
        end
        run_txn(5, 1, 1, 1'b0, 1'b0, 0, "R7 recovery after abort");

        // R8: a start while counting is ignored
        begin
            int first = 0;
            int pulses = 0;
            @(negedge clk);
            txn_start = 1'b1; txn_is_read = 1'b0; prog_lat = 8'd10; dec_speed = 2'd1; addr_phases = 2'd1;
            @(negedge clk);
            txn_start = 1'b0;
            for (int j = 1; j <= 16; j++) begin
                if (first_ready) begin pulses++; if (first == 0) first = j; end
                if (j == 3) begin txn_start = 1'b1; prog_lat = 8'd2; end
                if (j == 4) txn_start = 1'b0;
                @(negedge clk);
            end
            check(first == 10 && pulses == 1, "R8 start during count ignored", first * 100 + pulses, 1001);
        end

        // R10: a start in the ready cycle is accepted
        begin
            int first = 0;
            int pulses = 0;
            @(negedge clk);
            txn_start = 1'b1; txn_is_read = 1'b0; prog_lat = 8'd3; dec_speed = 2'd1; addr_phases = 2'd1;
            @(negedge clk);
            txn_start = 1'b0;
            for (int j = 1; j <= 3; j++) begin
                if (j == 3) begin
                    check(first_ready == 1'b1, "R6 first pulse at cycle 3", first_ready, 1);
                    txn_start = 1'b1; prog_lat = 8'd4;
                end
                @(negedge clk);
            end
            txn_start = 1'b0;
            for (int j = 1; j <= 8; j++) begin
                if (first_ready) begin pulses++; if (first == 0) first = j; end
                @(negedge clk);
            end
            check(first == 4 && pulses == 1, "R10 back-to-back start", first * 100 + pulses, 401);
        end

        // R6 and R2-R5: constrained random mix
        for (int i = 0; i < 80; i++) begin
            if ($urandom % 2 == 1) send_evt(int'($urandom % 8));
            run_txn(int'($urandom % 48), int'($urandom % 4), int'($urandom % 4),
                    1'($urandom % 2), 1'b0, 0, "R6 random transaction");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule